// File: doc/BRIEF.md
# Data Address Generator

This block forms the data-memory address for every instruction that touches memory, and it updates the chosen pointer register afterwards when the addressing option asks for it. It holds eight 16-bit address registers. Register 5 is the fixed index register and register 6 is the fixed page register. Either of them can also serve as an ordinary base or pointer.

Each request gives an addressing mode code, a register select, the 16-bit second instruction word and the 7-bit short offset taken from the low instruction bits. One clock edge later the block presents the address, together with a strobe that lasts one cycle. Any post-modification is written back on that same edge.

A separate load port writes any register directly. The address arithmetic always uses register values from before the edge. All arithmetic is 16-bit and wraps around, and no overflow is reported.

Top module: `dagu_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, all eight registers read zero, `ea` is zero and `ea_valid` is low.
- R2: When `ref_en` is sampled high on a clock edge, `ea_valid` is high for the following cycle and `ea` carries the new address. When `ref_en` is low, `ea_valid` drops and `ea` holds its value.
- R3: Mode code 0 (direct) gives `ea = operand` unchanged.
- R4: Mode code 1 (long relative) gives `ea = Rsel + operand` modulo 2^16 and leaves every register unchanged.
- R5: Mode code 2 (indexed) gives `ea = Rsel + R5` modulo 2^16 and leaves every register unchanged.
- R6: Mode codes 3, 4, 5 and 6 (indirect) give `ea = Rsel` as it was before the edge. On the same edge, Rsel is left alone (3), incremented by 1 (4), decremented by 1 (5) or has R5 added (6), all modulo 2^16.
- R7: Mode code 7 (short relative) gives `ea = R6 + short_off`, with the offset zero-extended. R6 is not modified.
- R8: Mode code 8 (global flag) gives `ea = short_off` zero-extended, which is an offset from a base of zero. `operand` and the registers have no effect.
- R9: Mode code 9 (page-relative flag) gives `ea = R6 + {short_off[6:1],1'b0}`. The offset's lowest bit is forced to zero.
- R10: When `ld_en` is high, register `ld_sel` takes `ld_data` on the edge. If a post-modify targets the same register on that edge, the load wins. A post-modify of a different register still takes effect.
- R11: Mode codes 10 to 15 give `ea = 0` and modify no register.
- R12: An address computed on an edge where a register is also being loaded uses the register's old value.
- R13: While `ref_en` is low, the mode inputs cause no post-modification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | A memory-referencing instruction is present this cycle |
| mode | input | 4 | Addressing mode code (see R3 to R11) |
| reg_sel | input | 3 | Base or pointer register select |
| operand | input | 16 | Second instruction word |
| short_off | input | 7 | Low instruction bits used as the short offset |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Register to load |
| ld_data | input | 16 | Value to load |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | High for one cycle after each request |

## Verification
The hardest case to reach from the ports is an edge where a load and a post-modify collide on the same register. In that case the old value must appear on `ea` and the loaded value must win in the register. The bench drives a post-increment request and a load to the same pointer in the same cycle. It then reads that pointer back through a non-modifying indirect request. A second collision is also driven: a load to the page register while a short-relative access reads it, which checks that the address uses the value from before the load.

// File: rtl/dagu_pkg.sv
// Package: shared mode encoding for the data address generator.
// Assumes a 4-bit mode field; codes 10..15 are unused.
package dagu_pkg;

    typedef enum logic [3:0] {
        MODE_DIRECT   = 4'd0,
        MODE_LONG_REL = 4'd1,
        MODE_INDEXED  = 4'd2,
        MODE_IND_KEEP = 4'd3,
        MODE_IND_INC  = 4'd4,
        MODE_IND_DEC  = 4'd5,
        MODE_IND_IDX  = 4'd6,
        MODE_SHORT    = 4'd7,
        MODE_FLAG_GLB = 4'd8,
        MODE_FLAG_PG  = 4'd9
    } addr_mode_e;

endpackage

// File: rtl/dagu_regfile.sv
// Module: address register file.
// Holds NREG registers of AW bits and exposes all of them combinationally.
// Two write sources: an explicit load and a post-modify write-back. When both
// target the same register, the load has priority. Synchronous active-low reset.
module dagu_regfile #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [SW-1:0]            ld_sel,
    input  logic [AW-1:0]            ld_data,
    input  logic                     pm_en,
    input  logic [SW-1:0]            pm_sel,
    input  logic [AW-1:0]            pm_data,
    output logic [NREG-1:0][AW-1:0]  regs
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic ld_hit;
        logic pm_hit;

        // Per-register decode of the two write sources.
        always_comb begin
            ld_hit = ld_en && (ld_sel == SW'(i));
            pm_hit = pm_en && (pm_sel == SW'(i));
        end

        // Register update: reset, then load, then post-modify.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (ld_hit) begin
                regs[i] <= ld_data;
            end else if (pm_hit) begin
                regs[i] <= pm_data;
            end
        end
    end

endmodule

// File: rtl/dagu_addr_calc.sv
// Module: effective address and post-modify computation (purely combinational).
// Reads the register file from before the edge. Produces the next address and,
// for post-modifying indirect modes, the write-back value. Everything wraps
// modulo 2^AW.
module dagu_addr_calc #(
    parameter int AW       = 16,
    parameter int NREG     = 8,
    parameter int OFFW     = 7,
    parameter int IDX_REG  = 5,
    parameter int PAGE_REG = 6,
    parameter int STEP     = 1,
    localparam int SW      = $clog2(NREG)
) (
    input  logic                     req,
    input  logic [3:0]               mode,
    input  logic [SW-1:0]            sel,
    input  logic [AW-1:0]            operand,
    input  logic [OFFW-1:0]          short_off,
    input  logic [NREG-1:0][AW-1:0]  regs,
    output logic [AW-1:0]            ea_next,
    output logic                     wb_en,
    output logic [AW-1:0]            wb_val
);
    import dagu_pkg::*;

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] base_v;
    logic [AW-1:0] idx_v;
    logic [AW-1:0] page_v;
    logic [AW-1:0] off_ext;
    logic [AW-1:0] flag_off;
    addr_mode_e    mode_e;

    // Operand selection and offset extension.
    always_comb begin
        base_v   = regs[sel];
        idx_v    = regs[IDX_REG];
        page_v   = regs[PAGE_REG];
        off_ext  = {{(AW-OFFW){1'b0}}, short_off};
        flag_off = {{(AW-OFFW){1'b0}}, short_off[OFFW-1:1], 1'b0};
        mode_e   = addr_mode_e'(mode);
    end

    // Address formation per mode.
    always_comb begin
        case (mode_e)
            MODE_DIRECT:   ea_next = operand;
            MODE_LONG_REL: ea_next = base_v + operand;
            MODE_INDEXED:  ea_next = base_v + idx_v;
            MODE_IND_KEEP,
            MODE_IND_INC,
            MODE_IND_DEC,
            MODE_IND_IDX:  ea_next = base_v;
            MODE_SHORT:    ea_next = page_v + off_ext;
            MODE_FLAG_GLB: ea_next = off_ext;
            MODE_FLAG_PG:  ea_next = page_v + flag_off;
            default:       ea_next = '0;
        endcase
    end

    // Post-modify value and enable, only while a request is present.
    always_comb begin
        wb_en  = 1'b0;
        wb_val = base_v;
        case (mode_e)
            MODE_IND_INC: begin
                wb_en  = req;
                wb_val = base_v + STEP_V;
            end
            MODE_IND_DEC: begin
                wb_en  = req;
                wb_val = base_v - STEP_V;
            end
            MODE_IND_IDX: begin
                wb_en  = req;
                wb_val = base_v + idx_v;
            end
            default: begin
                wb_en  = 1'b0;
                wb_val = base_v;
            end
        endcase
    end

endmodule

// File: rtl/dagu_out_stage.sv
// Module: output register for the effective address and its strobe.
// The strobe follows the request by one edge; the address holds when idle.
module dagu_out_stage #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] ea_next,
    output logic [AW-1:0] ea,
    output logic          ea_valid
);

    // Capture address on a request; the strobe lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea       <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea_valid <= req;
            if (req) begin
                ea <= ea_next;
            end
        end
    end

endmodule

// File: rtl/dagu_addr_gen.sv
// Module: data address generator top.
// Combines the register file, the address calculator and the output stage.
// Assumes the caller holds ref_en high for exactly one cycle per memory access.
module dagu_addr_gen #(
    parameter int AW       = 16,
    parameter int NREG     = 8,
    parameter int OFFW     = 7,
    parameter int IDX_REG  = 5,
    parameter int PAGE_REG = 6,
    parameter int STEP     = 1,
    localparam int SW      = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_en,
    input  logic [3:0]      mode,
    input  logic [SW-1:0]   reg_sel,
    input  logic [AW-1:0]   operand,
    input  logic [OFFW-1:0] short_off,
    input  logic            ld_en,
    input  logic [SW-1:0]   ld_sel,
    input  logic [AW-1:0]   ld_data,
    output logic [AW-1:0]   ea,
    output logic            ea_valid
);

    logic [NREG-1:0][AW-1:0] rf_q;
    logic [AW-1:0]           ea_next;
    logic                    wb_en;
    logic [AW-1:0]           wb_val;

    dagu_regfile #(.AW(AW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .pm_en   (wb_en),
        .pm_sel  (reg_sel),
        .pm_data (wb_val),
        .regs    (rf_q)
    );

    dagu_addr_calc #(
        .AW(AW), .NREG(NREG), .OFFW(OFFW),
        .IDX_REG(IDX_REG), .PAGE_REG(PAGE_REG), .STEP(STEP)
    ) u_calc (
        .req       (ref_en),
        .mode      (mode),
        .sel       (reg_sel),
        .operand   (operand),
        .short_off (short_off),
        .regs      (rf_q),
        .ea_next   (ea_next),
        .wb_en     (wb_en),
        .wb_val    (wb_val)
    );

    dagu_out_stage #(.AW(AW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (ref_en),
        .ea_next  (ea_next),
        .ea       (ea),
        .ea_valid (ea_valid)
    );

endmodule

// File: rtl/dagu_addr_gen_chk.sv
// Module: property checker for the data address generator, bound to the top.
// Observes ports and the register file contents; drives nothing.
module dagu_addr_gen_chk #(
    parameter int AW       = 16,
    parameter int NREG     = 8,
    parameter int OFFW     = 7,
    parameter int PAGE_REG = 6,
    localparam int SW      = $clog2(NREG)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ref_en,
    input logic [3:0]              mode,
    input logic [SW-1:0]           reg_sel,
    input logic [AW-1:0]           operand,
    input logic [OFFW-1:0]         short_off,
    input logic                    ld_en,
    input logic [SW-1:0]           ld_sel,
    input logic [AW-1:0]           ld_data,
    input logic [AW-1:0]           ea,
    input logic                    ea_valid,
    input logic [NREG-1:0][AW-1:0] rf_q
);

    // R2: strobe follows the request by exactly one edge.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en |=> ea_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> (!ea_valid && $stable(ea)));

    // R3: direct mode passes the operand through.
    a_r3_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && mode == 4'd0) |=> ea == $past(operand));

    // R8: global flag address sits in the low offset window from zero.
    a_r8_global_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && mode == 4'd8) |=> ea == {{(AW-OFFW){1'b0}}, $past(short_off)});

    // R9: page-relative flag address differs from the page by an even amount.
    a_r9_flag_even: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && mode == 4'd9) |=> ((ea - $past(rf_q[PAGE_REG])) & AW'(1)) == '0);

    // R6: post-increment writes old value plus one unless a load collides.
    a_r6_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && mode == 4'd4 && !(ld_en && ld_sel == reg_sel))
        |=> rf_q[$past(reg_sel)] == $past(rf_q[reg_sel]) + AW'(1));

    // R10: an explicit load always lands.
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> rf_q[$past(ld_sel)] == $past(ld_data));

    // R13: with no request and no load the register file is frozen.
    a_r13_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en && !ld_en) |=> $stable(rf_q));

endmodule

bind dagu_addr_gen dagu_addr_gen_chk #(
    .AW(AW), .NREG(NREG), .OFFW(OFFW), .PAGE_REG(PAGE_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_en    (ref_en),
    .mode      (mode),
    .reg_sel   (reg_sel),
    .operand   (operand),
    .short_off (short_off),
    .ld_en     (ld_en),
    .ld_sel    (ld_sel),
    .ld_data   (ld_data),
    .ea        (ea),
    .ea_valid  (ea_valid),
    .rf_q      (rf_q)
);

// File: tb/dagu_addr_gen_test.sv
`timescale 1ns/1ps
// Bench: vector table for non-modifying modes, then directed corner cases.
module dagu_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] operand = '0;
    logic [6:0]  short_off = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] ea;
    logic        ea_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dagu_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .mode(mode),
        .reg_sel(reg_sel), .operand(operand), .short_off(short_off),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .ea(ea), .ea_valid(ea_valid)
    );

    // {mode, sel, operand, offset, expected ea}; registers preloaded below.
    localparam int NV = 11;
    localparam logic [45:0] VEC [NV] = '{
        {4'd0, 3'd3, 16'hABCD, 7'h00, 16'hABCD},  // R3 direct
        {4'd1, 3'd0, 16'h0234, 7'h00, 16'h1234},  // R4 long relative
        {4'd1, 3'd1, 16'h0002, 7'h00, 16'h0001},  // R4 wrap
        {4'd2, 3'd2, 16'h0000, 7'h00, 16'h0014},  // R5 indexed
        {4'd2, 3'd7, 16'h0000, 7'h00, 16'h0002},  // R5 wrap
        {4'd7, 3'd0, 16'h0000, 7'h7F, 16'h027F},  // R7 max offset
        {4'd7, 3'd0, 16'h0000, 7'h05, 16'h0205},  // R7
        {4'd8, 3'd6, 16'hFFFF, 7'h55, 16'h0055},  // R8 global flag
        {4'd9, 3'd0, 16'h0000, 7'h55, 16'h0254},  // R9 lsb forced low
        {4'd3, 3'd4, 16'h0000, 7'h00, 16'h0001},  // R6 keep
        {4'd11, 3'd0, 16'h1234, 7'h10, 16'h0000}  // R11 unused code
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One request, optionally with a load; returns at the next negedge.
    task automatic issue(input logic [3:0] m, input logic [2:0] s, input logic [15:0] op,
                         input logic [6:0] off, input logic dl, input logic [2:0] ls,
                         input logic [15:0] ld);
        ref_en = 1'b1; mode = m; reg_sel = s; operand = op; short_off = off;
        ld_en = dl; ld_sel = ls; ld_data = ld;
        @(negedge clk);
        ref_en = 1'b0; ld_en = 1'b0;
    endtask

    task automatic load(input logic [2:0] s, input logic [15:0] d);
        ld_en = 1'b1; ld_sel = s; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Read a register back through a non-modifying indirect access.
    task automatic peek(input string tag, input logic [2:0] s, input logic [15:0] exp);
        issue(4'd3, s, 16'h0, 7'h0, 1'b0, 3'd0, 16'h0);
        check(tag, ea, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ea reset", ea, 16'h0);
        check("R1 valid reset", {15'h0, ea_valid}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) peek($sformatf("R1 reg %0d reset", i), 3'(i), 16'h0);

        load(3'd0, 16'h1000); load(3'd1, 16'hFFFF); load(3'd2, 16'h0010);
        load(3'd3, 16'h8000); load(3'd4, 16'h0001); load(3'd5, 16'h0004);
        load(3'd6, 16'h0200); load(3'd7, 16'hFFFE);

        for (int v = 0; v < NV; v++) begin
            issue(VEC[v][45:42], VEC[v][41:39], VEC[v][38:23], VEC[v][22:16], 1'b0, 3'd0, 16'h0);
            check($sformatf("R3-R11 vector %0d", v), ea, VEC[v][15:0]);
            check("R2 strobe", {15'h0, ea_valid}, 16'h1);
        end
        // R4 R5 R7 R11: no register changed by the vectors
        peek("R4 base unchanged", 3'd0, 16'h1000);
        peek("R4 base unchanged r1", 3'd1, 16'hFFFF);
        peek("R5 base unchanged", 3'd2, 16'h0010);
        peek("R7 page unchanged", 3'd6, 16'h0200);
        peek("R11 reg unchanged", 3'd7, 16'hFFFE);

        // R2: idle cycle drops strobe and holds address
        @(negedge clk);
        check("R2 strobe drops", {15'h0, ea_valid}, 16'h0);
        check("R2 ea holds", ea, 16'hFFFE);

        // R6 post modes
        issue(4'd4, 3'd1, 16'h0, 7'h0, 1'b0, 3'd0, 16'h0);
        check("R6 inc old addr", ea, 16'hFFFF);
        peek("R6 inc wraps", 3'd1, 16'h0000);
        issue(4'd5, 3'd4, 16'h0, 7'h0, 1'b0, 3'd0, 16'h0);
        check("R6 dec old addr", ea, 16'h0001);
        issue(4'd5, 3'd4, 16'h0, 7'h0, 1'b0, 3'd0, 16'h0);
        check("R6 dec second", ea, 16'h0000);
        peek("R6 dec wraps", 3'd4, 16'hFFFF);
        issue(4'd6, 3'd0, 16'h0, 7'h0, 1'b0, 3'd0, 16'h0);
        check("R6 idx old addr", ea, 16'h1000);
        peek("R6 idx added", 3'd0, 16'h1004);

        // R10: load and post-modify collide on one register
        issue(4'd4, 3'd2, 16'h0, 7'h0, 1'b1, 3'd2, 16'h7777);
        check("R10 collide addr", ea, 16'h0010);
        peek("R10 load wins", 3'd2, 16'h7777);
        issue(4'd4, 3'd3, 16'h0, 7'h0, 1'b1, 3'd7, 16'h1111);
        peek("R10 other post-mod", 3'd3, 16'h8001);
        peek("R10 other load", 3'd7, 16'h1111);

        // R12: page loaded on the same edge as a short-relative read
        issue(4'd7, 3'd0, 16'h0, 7'h01, 1'b1, 3'd6, 16'h0300);
        check("R12 old page used", ea, 16'h0201);
        peek("R12 page loaded", 3'd6, 16'h0300);

        // R13: mode present without request modifies nothing
        mode = 4'd4; reg_sel = 3'd0; ref_en = 1'b0;
        @(negedge clk);
        check("R13 no strobe", {15'h0, ea_valid}, 16'h0);
        peek("R13 reg untouched", 3'd0, 16'h1004);

        // R1: mid-run reset clears registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ea after reset", ea, 16'h0);
        peek("R1 reg cleared", 3'd3, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule